// File: doc/BRIEF.md
# Rotate And Mask Unit

This block performs the word-sized rotate-then-mask operations of a 64-bit integer pipeline. The low 32 bits of the source register are copied into both halves of a 64-bit value. That value is rotated left, and the rotated value is then combined with a bit mask. The mask is built from two bit indices that come from the operation word.

Three operating modes are available:
- The rotated value is ANDed with the mask, using a shift amount taken from the operation word.
- The rotated value is inserted into the destination's previous contents wherever the mask is set.
- The rotated value is ANDed with the mask, using a shift amount taken from the low bits of a register value.

The caller presents all operands together with a one-cycle start strobe. One cycle later the block presents a registered 64-bit result, a done pulse and a record request. The record request tells downstream logic to update a condition field from the result.

The mask indices count from the most significant bit of the 32-bit word. When the end index is below the begin index, the run of ones wraps around and leaves a run of zeros in the middle. The upper half of the mask is then all ones rather than all zeros. As a result, the duplicated upper half of the rotated value shows through in that case.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` becomes zero and `done` and `rec_req` become 0.
- R2: A cycle with `start` high makes `done` high in the next cycle. A cycle with `start` low makes `done` low in the next cycle, and `result` keeps its value.
- R3: The fields of `op_word` are fixed. Bit 0 is the record bit, bits 5:1 are the mask end index, bits 10:6 are the mask begin index, and bits 15:11 are the immediate shift amount. Bits 31:16 are ignored.
- R4: When end >= begin, the mask has ones at word indices begin through end inclusive. Word index i is bit 31-i of the 64-bit value. All other low bits of the mask are zero, and mask bits 63:32 are zero.
- R5: When end < begin, the low mask bits are ones at word indices from begin to 31 and from 0 to end, with zeros in between. Mask bits 63:32 are all ones.
- R6: Only `src_val[31:0]` is used. It is placed in both halves of a 64-bit value, and that value is rotated left, which equals rotating the word left in each half. `src_val[63:32]` has no effect on `result`.
- R7: In mode 0, `result` = rotated & mask, using the immediate shift amount.
- R8: In mode 1, `result` = (`dest_old` & ~mask) | (rotated & mask), using the immediate shift amount.
- R9: In mode 2, the shift amount is `shift_val[4:0]`. The immediate shift field and `shift_val[63:5]` have no effect, and `result` = rotated & mask.
- R10: A shift amount of zero leaves the duplicated value unrotated.
- R11: `rec_req` takes the value of the record bit with the same latency as `result`.
- R12: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operands valid; launch an operation |
| mode | input | 2 | 0 AND with immediate shift, 1 insert, 2 AND with register shift, 3 same as 0 |
| op_word | input | 32 | Operation word carrying record bit, mask indices and immediate shift |
| src_val | input | 64 | Source register; low word is rotated |
| dest_old | input | 64 | Destination's previous value for insert mode |
| shift_val | input | 64 | Register supplying the shift amount in mode 2 |
| result | output | 64 | Registered result |
| done | output | 1 | One-cycle pulse after each start |
| rec_req | output | 1 | Registered condition-field update request |

## Verification
The bench builds the block with its default 64-bit register and 32-bit word. This keeps the index fields at five bits, so every begin/end pair can be swept: 1024 pairs in each of the four modes, covering every wrapped and unwrapped mask shape. The shift amounts vary across that sweep, and a separate pass walks all 32 shift values at one fixed mask, zero included. Random upper source bits, upper operation-word bits and upper shift-register bits are applied on every vector, which confirms that they are ignored.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  typedef enum logic [1:0] {
    RM_AND_IMM = 2'd0,
    RM_INSERT  = 2'd1,
    RM_AND_REG = 2'd2,
    RM_ALT_IMM = 2'd3
  } rm_mode_e;

  localparam int unsigned REC_POS = 0;
  localparam int unsigned END_LSB = 1;
  localparam int unsigned BEG_LSB = 6;
  localparam int unsigned SH_LSB  = 11;
endpackage

// File: rtl/rmu_mask_gen.sv
module rmu_mask_gen #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32,
  localparam int unsigned IW = $clog2(WLEN)
) (
  input  logic [IW-1:0]   mb,
  input  logic [IW-1:0]   me,
  output logic [XLEN-1:0] mask
);
  // Low word of ones, and a seed whose ones start at the word's MSB and fill upward.
  localparam logic [XLEN-1:0] LOW_ONES = {{(XLEN-WLEN){1'b0}}, {WLEN{1'b1}}};
  localparam logic signed [XLEN-1:0] TOP_SEED =
    {{(XLEN-WLEN+1){1'b1}}, {(WLEN-1){1'b0}}};

  logic [XLEN-1:0] left_part;
  logic [XLEN-1:0] right_part;
  logic [XLEN-1:0] carry_fix;

  assign left_part  = LOW_ONES >> mb;
  assign right_part = TOP_SEED >>> me;
  assign carry_fix  = {{(XLEN-1){1'b0}}, (me >= mb)};
  // Sum wraps modulo 2^XLEN; wrapped masks leave the upper half set.
  assign mask = left_part + right_part + carry_fix;
endmodule

// File: rtl/rmu_rotator.sv
module rmu_rotator #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32,
  localparam int unsigned SW = $clog2(WLEN),
  localparam int unsigned REPS = XLEN / WLEN
) (
  input  logic [WLEN-1:0] word,
  input  logic [SW-1:0]   amt,
  output logic [XLEN-1:0] rotated
);
  logic [XLEN-1:0]   dup;
  logic [2*XLEN-1:0] wide;

  for (genvar g = 0; g < REPS; g++) begin : g_dup
    assign dup[g*WLEN +: WLEN] = word;
  end

  // Rotate by shifting a doubled copy; amount zero yields dup unchanged.
  assign wide    = {dup, dup} << amt;
  assign rotated = wide[2*XLEN-1:XLEN];
endmodule

// File: rtl/rmu_merge.sv
module rmu_merge
  import rmu_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  rm_mode_e        mode,
  input  logic [XLEN-1:0] rotated,
  input  logic [XLEN-1:0] mask,
  input  logic [XLEN-1:0] dest_old,
  output logic [XLEN-1:0] merged
);
  always_comb begin
    if (mode == RM_INSERT) merged = (dest_old & ~mask) | (rotated & mask);
    else                   merged = rotated & mask;
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rmu_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32,
  parameter int unsigned OPW  = 32,
  localparam int unsigned SW  = $clog2(WLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      mode,
  input  logic [OPW-1:0]  op_word,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] dest_old,
  input  logic [XLEN-1:0] shift_val,
  output logic [XLEN-1:0] result,
  output logic            done,
  output logic            rec_req
);
  rm_mode_e        mode_e;
  logic [SW-1:0]   f_beg;
  logic [SW-1:0]   f_end;
  logic [SW-1:0]   f_sh;
  logic [SW-1:0]   amt;
  logic [XLEN-1:0] mask_w;
  logic [XLEN-1:0] rot_w;
  logic [XLEN-1:0] merged_w;

  assign mode_e = rm_mode_e'(mode);
  assign f_beg  = op_word[BEG_LSB +: SW];
  assign f_end  = op_word[END_LSB +: SW];
  assign f_sh   = op_word[SH_LSB +: SW];
  assign amt    = (mode_e == RM_AND_REG) ? shift_val[SW-1:0] : f_sh;

  rmu_mask_gen #(.XLEN(XLEN), .WLEN(WLEN)) u_mask (
    .mb(f_beg), .me(f_end), .mask(mask_w)
  );

  rmu_rotator #(.XLEN(XLEN), .WLEN(WLEN)) u_rot (
    .word(src_val[WLEN-1:0]), .amt(amt), .rotated(rot_w)
  );

  rmu_merge #(.XLEN(XLEN)) u_merge (
    .mode(mode_e), .rotated(rot_w), .mask(mask_w),
    .dest_old(dest_old), .merged(merged_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      done    <= 1'b0;
      rec_req <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result  <= merged_w;
        rec_req <= op_word[REC_POS];
      end
    end
  end
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32,
  parameter int unsigned OPW  = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [1:0]      mode,
  input logic [OPW-1:0]  op_word,
  input logic [XLEN-1:0] dest_old,
  input logic [XLEN-1:0] result,
  input logic            done,
  input logic            rec_req,
  input logic [XLEN-1:0] mask_w
);
  logic [4:0] beg_f;
  logic [4:0] end_f;
  assign beg_f = op_word[10:6];
  assign end_f = op_word[5:1];

  a_r2_done_follows_start: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!done && $stable(result)));
  a_r11_record_bit: assert property (@(posedge clk) disable iff (rst)
    start |=> (rec_req == $past(op_word[0])));
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (end_f >= beg_f) |-> (mask_w[XLEN-1:WLEN] == '0));
  a_r5_upper_set: assert property (@(posedge clk) disable iff (rst)
    (end_f < beg_f) |-> (&mask_w[XLEN-1:WLEN]));
  a_r4_endpoints_set: assert property (@(posedge clk) disable iff (rst)
    start |-> (mask_w[WLEN-1-beg_f] && mask_w[WLEN-1-end_f]));
  a_r8_insert_keeps_old: assert property (@(posedge clk) disable iff (rst)
    (start && mode == 2'd1) |=> (((result ^ $past(dest_old)) & ~$past(mask_w)) == '0));
  a_r7_and_clears_outside: assert property (@(posedge clk) disable iff (rst)
    (start && mode != 2'd1) |=> ((result & ~$past(mask_w)) == '0));
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN), .WLEN(WLEN), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .op_word(op_word),
  .dest_old(dest_old), .result(result), .done(done), .rec_req(rec_req),
  .mask_w(mask_w)
);

// File: tb/rotmask_unit_bench.sv
module rotmask_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] op_word = '0;
  logic [63:0] src_val = '0;
  logic [63:0] dest_old = '0;
  logic [63:0] shift_val = '0;
  logic [63:0] result;
  logic        done;
  logic        rec_req;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  always #4ns clk = ~clk;

  rotmask_unit u_rotmask_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .op_word(op_word),
    .src_val(src_val), .dest_old(dest_old), .shift_val(shift_val),
    .result(result), .done(done), .rec_req(rec_req)
  );

  function automatic logic [63:0] next_rand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  function automatic logic [63:0] ref_mask(int b, int e);
    logic [63:0] m;
    m = (e >= b) ? 64'h0 : 64'hffff_ffff_0000_0000;
    for (int i = 0; i < 32; i++) begin
      if ((e >= b) ? (i >= b && i <= e) : (i >= b || i <= e)) m[31-i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] rotl32(logic [31:0] w, int n);
    if (n == 0) return w;
    return (w << n) | (w >> (32 - n));
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic run(int md, int b, int e, int sh, bit rec, logic [63:0] src,
                     logic [63:0] dst, logic [63:0] shv, string tag);
    logic [31:0] r32;
    logic [63:0] rot, m, exp_res;
    int amt;
    mode      = md[1:0];
    op_word   = {next_rand() & 32'hffff, 16'h0} | (sh[4:0] << 11) |
                (b[4:0] << 6) | (e[4:0] << 1) | {31'h0, rec};
    src_val   = src;
    dest_old  = dst;
    shift_val = shv;
    start     = 1'b1;
    amt = (md == 2) ? int'(shv[4:0]) : sh;
    r32 = rotl32(src[31:0], amt);
    rot = {r32, r32};
    m   = ref_mask(b, e);
    exp_res = (md == 1) ? ((dst & ~m) | (rot & m)) : (rot & m);
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (result !== exp_res || done !== 1'b1 || rec_req !== rec) begin
      n_bad++;
      $display("FAIL %s: result=%h done=%b rec=%b expected result=%h done=1 rec=%b",
               tag, result, done, rec_req, exp_res, rec);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;  // R1 reset state
    if (result !== 64'h0 || done !== 1'b0 || rec_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: result=%h done=%b rec=%b expected 0 0 0", result, done, rec_req);
    end
    rst = 1'b0;

    // R3 R4 R5 R7 R8 R9 R12: every begin/end pair in every mode
    for (int md = 0; md < 4; md++) begin
      for (int b = 0; b < 32; b++) begin
        for (int e = 0; e < 32; e++) begin
          string tg;
          tg = (md == 1) ? "R8" : (md == 2) ? "R9" : (md == 3) ? "R12" : "R7";
          tg = {tg, (e >= b) ? " R4 R3" : " R5 R3"};
          run(md, b, e, (b * 7 + e * 3 + md) % 32, bit'((b + e) % 2),
              next_rand(), next_rand(), next_rand(), tg);
        end
      end
    end

    // R10: all shift amounts, including zero, with an immediate and a register source
    for (int s = 0; s < 32; s++) begin
      run(0, 0, 31, s, 1'b0, 64'h0123_4567_89ab_cdef, 64'h0, 64'h0, "R10 R7");
      run(2, 4, 27, 31 - s, 1'b1, 64'hdead_beef_8000_0001,
          64'h0, {next_rand() & 64'hffff_ffff_ffff_ffe0} | s, "R10 R9");
    end

    // R6: upper source word must not matter
    run(0, 20, 3, 9, 1'b0, 64'h0000_0000_a5a5_3c3c, 64'h0, 64'h0, "R6");
    run(0, 20, 3, 9, 1'b0, 64'hffff_ffff_a5a5_3c3c, 64'h0, 64'h0, "R6");
    run(1, 31, 0, 0, 1'b1, 64'h7777_7777_0000_0001, 64'hffff_ffff_ffff_ffff, 64'h0, "R6 R8");

    // R2: idle cycle drops done and holds result
    start = 1'b0;
    held = result;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (done !== 1'b0 || result !== held) begin
      n_bad++;
      $display("FAIL R2: done=%b result=%h expected done=0 result=%h", done, result, held);
    end

    // R11: record bit set then cleared
    run(0, 8, 8, 1, 1'b1, 64'h1, 64'h0, 64'h0, "R11");
    run(0, 8, 8, 1, 1'b0, 64'h1, 64'h0, 64'h0, "R11");

    summary();
    $finish;
  end
endmodule